// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch with Word Prefetch and Direct-Mapped Cache

This block connects a byte-wide instruction fetch port to a program flash that returns one 32-bit word per read and is four times slower than the core clock. The current word is held in a 4-byte buffer, so sequential bytes are delivered one per core cycle. Whenever a new word enters that buffer, a flash read of the following word starts, so a stream entered at byte 0 never waits for the flash.

Jumps and loops are covered by a 64-line direct-mapped cache of 32-bit words. Every word returned by the flash is written into the cache. A fetch that misses the buffer but hits the cache is served in the same cycle. Only a fetch that misses both the buffer and the cache raises stall, and the flash read it needs starts as soon as the flash is free. A prefetch that the core has jumped away from is dropped. A synchronous invalidate empties the cache and the buffer.

The flash array is modelled inside the block as a memory with a fixed latency and computed contents. Its read strobe and word address are brought out for observation.

Top module: `pfc_fetch_unit`

## Requirements
- R1: After reset no flash read is issued while no fetch is requested, and the buffer and all cache lines are empty, so the first fetch misses.
- R2: A flash read issued in cycle t returns its word in cycle t+4, and only one read is outstanding at a time. The word at word address w is (w * 0x9E3779B1) XOR 0x5A5A0F0F, taken modulo 2^32.
- R3: Byte k of a word (k = fetch_addr[1:0]) is bits [8k+7:8k]. It appears on fetch_data in the same cycle as the request, whenever stall is low.
- R4: A fetch whose word is already in the prefetch buffer never stalls.
- R5: When a word enters the buffer from the flash or from the cache, a read of the next word address starts in that same cycle if the flash is idle, or otherwise in the first idle cycle. A 16-byte sequential run from a cold start stalls 4 cycles in total.
- R6: The cache has 64 direct-mapped lines, indexed by fetch_addr[7:2] and tagged by the upper address bits. A hit is served in the same cycle with no stall. A line is replaced by any returned word with the same index.
- R7: A fetch that misses both the buffer and the cache holds stall high. Its flash read is issued in the first cycle the flash is idle, and stall drops in the cycle the word returns. With the flash idle, this is exactly 4 stall cycles.
- R8: A flash read still in flight when a fetch for a different, non-buffered word arrives is discarded. Its word is neither delivered nor cached, and the new read starts in the cycle the discarded read completes.
- R9: An invalidate pulse empties the buffer and every cache line and discards any read in flight, so later fetches miss.
- R10: Stall is low whenever fetch_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval | input | 1 | Empty cache and prefetch buffer |
| fetch_valid | input | 1 | Core requests a byte this cycle |
| fetch_addr | input | ADDR_W | Byte address of the request |
| fetch_data | output | 8 | Requested byte, valid when stall is low |
| fetch_stall | output | 1 | Request cannot be served this cycle |
| flash_rd | output | 1 | Flash word read starts this cycle |
| flash_rd_word | output | ADDR_W-2 | Word address of the read being started |

## Verification
The bench uses the default parameters: a 12-bit byte address, 64 cache lines and a four-cycle flash latency. Random fetch runs are confined to the first kilobyte, so each cache index is shared by four word addresses, which makes evictions and tag mismatches frequent. Directed runs place a jump exactly while a prefetch is in flight, which exercises the discard and restart timing. The reference model reproduces the cycle in which each word becomes available, so every stall cycle and every prefetch strobe is compared, not only the delivered bytes.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    // Source that serves the current byte request
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BUF   = 2'd1,
        SRC_RET   = 2'd2,
        SRC_CACHE = 2'd3
    } src_e;

    // Content of the modelled flash array at a word address
    function automatic logic [31:0] flash_word(input logic [31:0] w);
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

endpackage

// File: rtl/pfc_flash_model.sv
module pfc_flash_model
    import pfc_pkg::*;
#(
    parameter int WAW = 10,
    parameter int LAT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req,
    input  logic [WAW-1:0] rd_word,
    output logic           busy,
    output logic           done,
    output logic [WAW-1:0] word,
    output logic [31:0]    data
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic [WAW-1:0] word;
        logic           done;
        logic [31:0]    data;
    } fl_st_t;

    fl_st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.busy) begin
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.data = flash_word(32'(q.word));
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (rd_req) begin
            d.busy = 1'b1;
            d.cnt  = CW'(LAT - 1);
            d.word = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;
    assign word = q.word;
    assign data = q.data;

    AST_ONE_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !q.busy);  // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.busy));  // R2

endmodule

// File: rtl/pfc_icache.sv
module pfc_icache #(
    parameter int WAW   = 10,
    parameter int LINES = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inval,
    input  logic [WAW-1:0] lk_word,
    output logic           lk_hit,
    output logic [31:0]    lk_data,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_word,
    input  logic [31:0]    wr_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = WAW - IDX_W;

    logic [LINES-1:0]            valid_q, valid_d;
    logic [LINES-1:0][TAG_W-1:0] tag_q;
    logic [LINES-1:0][31:0]      data_q;

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    assign lk_idx = lk_word[IDX_W-1:0];
    assign lk_tag = lk_word[WAW-1:IDX_W];
    assign wr_idx = wr_word[IDX_W-1:0];
    assign wr_tag = wr_word[WAW-1:IDX_W];

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data = data_q[lk_idx];

    always_comb begin
        valid_d = valid_q;
        if (inval) begin
            valid_d = '0;
        end else if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inval) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !lk_hit);  // R9
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inval) |=> ((lk_word != $past(wr_word)) || lk_hit));  // R6

endmodule

// File: rtl/pfc_fetch_unit.sv
module pfc_fetch_unit
    import pfc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CACHE_LINES = 64,
    parameter int FLASH_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [7:0]        fetch_data,
    output logic              fetch_stall,
    output logic              flash_rd,
    output logic [ADDR_W-3:0] flash_rd_word
);
    localparam int WAW = ADDR_W - 2;

    typedef struct packed {
        logic           buf_v;
        logic [WAW-1:0] buf_w;
        logic [31:0]    buf_data;
        logic           disc;
        logic           pf_v;
        logic [WAW-1:0] pf_w;
    } st_t;

    st_t q, d;

    logic           fl_busy, fl_done;
    logic [WAW-1:0] fl_word;
    logic [31:0]    fl_data;
    logic           c_hit, c_wr;
    logic [31:0]    c_data;

    logic [WAW-1:0] rw;
    logic [1:0]     off;
    src_e           src;
    logic [31:0]    word_sel;
    logic           buf_hit, ret_ok, ret_hit, new_word, miss;
    logic           rd;
    logic [WAW-1:0] rd_w;

    assign rw  = fetch_addr[ADDR_W-1:2];
    assign off = fetch_addr[1:0];

    pfc_flash_model #(.WAW(WAW), .LAT(FLASH_LAT)) u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd),
        .rd_word (rd_w),
        .busy    (fl_busy),
        .done    (fl_done),
        .word    (fl_word),
        .data    (fl_data)
    );

    pfc_icache #(.WAW(WAW), .LINES(CACHE_LINES)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .inval   (inval),
        .lk_word (rw),
        .lk_hit  (c_hit),
        .lk_data (c_data),
        .wr_en   (c_wr),
        .wr_word (fl_word),
        .wr_data (fl_data)
    );

    // Source selection: buffer first, then the returning flash word, then the cache
    always_comb begin
        buf_hit = q.buf_v && (q.buf_w == rw);
        ret_ok  = fl_done && !q.disc;
        ret_hit = ret_ok && (fl_word == rw);
        if (!fetch_valid)  src = SRC_NONE;
        else if (buf_hit)  src = SRC_BUF;
        else if (ret_hit)  src = SRC_RET;
        else if (c_hit)    src = SRC_CACHE;
        else               src = SRC_NONE;
        case (src)
            SRC_BUF:   word_sel = q.buf_data;
            SRC_RET:   word_sel = fl_data;
            SRC_CACHE: word_sel = c_data;
            default:   word_sel = q.buf_data;
        endcase
        miss     = fetch_valid && (src == SRC_NONE);
        new_word = (src == SRC_RET) || (src == SRC_CACHE);
        c_wr     = ret_ok && !inval;
    end

    // Read issue and next state
    always_comb begin
        d    = q;
        rd   = 1'b0;
        rd_w = rw;
        if (!fl_busy && !inval) begin
            if (miss) begin
                rd   = 1'b1;
                rd_w = rw;
            end else if (new_word) begin
                rd   = 1'b1;
                rd_w = rw + 1'b1;
            end else if (q.pf_v) begin
                rd   = 1'b1;
                rd_w = q.pf_w;
            end
        end

        if (new_word) begin
            d.buf_v    = 1'b1;
            d.buf_w    = rw;
            d.buf_data = word_sel;
        end

        if (fl_done) begin
            d.disc = 1'b0;
        end
        if (fl_busy && !q.disc &&
            (inval || (fetch_valid && !buf_hit && (rw != fl_word)))) begin
            d.disc = 1'b1;
        end

        if (miss || inval) begin
            d.pf_v = 1'b0;
        end else if (new_word) begin
            d.pf_v = !rd;
            d.pf_w = rw + 1'b1;
        end else if (rd) begin
            d.pf_v = 1'b0;
        end

        if (inval) begin
            d.buf_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fetch_data    = word_sel[{off, 3'b000} +: 8];
    assign fetch_stall   = miss;
    assign flash_rd      = rd;
    assign flash_rd_word = rd_w;

    AST_STALL_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && !inval) |-> (fl_busy || flash_rd));  // R7
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !fetch_stall);  // R10
    AST_DISC_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        q.disc |-> (fl_busy || fl_done));  // R8
    AST_INVAL_DROPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !q.buf_v);  // R9
    AST_SAME_WORD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid && !fetch_stall && !inval) &&
         (rw == $past(rw))) |-> !fetch_stall);  // R4

endmodule

// File: tb/tb_pfc_fetch_unit.sv
`timescale 1ns/1ps
module tb_pfc_fetch_unit;
    localparam int ADDR_W = 12;
    localparam int LINES  = 64;
    localparam int LAT    = 4;
    localparam int WORDS  = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inval = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic [7:0]        fetch_data;
    logic              fetch_stall;
    logic              flash_rd;
    logic [ADDR_W-3:0] flash_rd_word;

    always #2.5 clk = ~clk;

    pfc_fetch_unit #(.ADDR_W(ADDR_W), .CACHE_LINES(LINES), .FLASH_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .inval(inval), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data), .fetch_stall(fetch_stall),
        .flash_rd(flash_rd), .flash_rd_word(flash_rd_word)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural reference state
    int cyc = 0;
    bit m_bv = 0;
    int m_bw = 0;
    int m_ctag [LINES];
    bit f_on = 0;
    bit f_disc = 0;
    int f_word = 0;
    int f_ready = 0;
    bit p_v = 0;
    int p_w = 0;
    bit e_stall = 0;

    function automatic logic [31:0] fw(input int w);
        logic [31:0] x;
        x = 32'(w);
        return (x * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input bit v, input int a_in, input bit inv);
        int a, rw, off, rdw, exp_b;
        bit fb, fd, ret, bh, rh, ch, srv, st, nw, rd;
        @(negedge clk);
        a = a_in % (1 << ADDR_W);
        fetch_valid = v;
        fetch_addr  = ADDR_W'(a);
        inval       = inv;
        #1;
        rw  = a >> 2;
        off = a & 3;
        fb  = f_on && (cyc < f_ready);
        fd  = f_on && (cyc == f_ready);
        ret = fd && !f_disc;
        bh  = m_bv && (m_bw == rw);
        rh  = ret && (f_word == rw);
        ch  = (m_ctag[rw % LINES] == rw);
        srv = v && (bh || rh || ch);
        st  = v && !srv;
        nw  = srv && !bh;
        rd  = 0;
        rdw = 0;
        if (!fb && !inv) begin
            if (st) begin
                rd = 1; rdw = rw;
            end else if (nw) begin
                rd = 1; rdw = (rw + 1) % WORDS;
            end else if (p_v) begin
                rd = 1; rdw = p_w;
            end
        end
        chk(fetch_stall == st, v ? "R7" : "R10", "stall", int'(fetch_stall), int'(st));
        if (srv) begin
            exp_b = int'((fw(rw) >> (8 * off)) & 32'hFF);
            chk(int'(fetch_data) == exp_b, "R3", "byte", int'(fetch_data), exp_b);
        end
        chk(flash_rd == rd, "R5", "read strobe", int'(flash_rd), int'(rd));
        if (rd) chk(int'(flash_rd_word) == rdw, "R5", "read word", int'(flash_rd_word), rdw);
        // state update at the coming edge
        if (ret && !inv) m_ctag[f_word % LINES] = f_word;
        if (fd) begin
            f_on = 0; f_disc = 0;
        end
        if (fb && !f_disc && (inv || (v && !bh && rw != f_word))) f_disc = 1;
        if (nw) begin
            m_bv = 1; m_bw = rw;
        end
        if (st || inv) p_v = 0;
        else if (nw) begin
            p_v = !rd; p_w = (rw + 1) % WORDS;
        end else if (rd) p_v = 0;
        if (inv) begin
            m_bv = 0;
            foreach (m_ctag[i]) m_ctag[i] = -1;
        end
        if (rd) begin
            f_on = 1; f_disc = 0; f_word = rdw; f_ready = cyc + LAT;
        end
        cyc++;
        e_stall = st;
    endtask

    task automatic fetch(input int a, output int stalls);
        stalls = 0;
        do begin
            cycle(1, a, 0);
            if (e_stall) stalls++;
        end while (e_stall && stalls < 100);
    endtask

    task automatic run(input int a0, input int n, output int tot);
        int s;
        tot = 0;
        for (int i = 0; i < n; i++) begin
            fetch(a0 + i, s);
            tot += s;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s;
        logic [31:0] rs;
        foreach (m_ctag[i]) m_ctag[i] = -1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no request
        cycle(0, 0, 0);
        chk(fetch_stall == 1'b0, "R1", "idle stall", int'(fetch_stall), 0);
        chk(flash_rd == 1'b0, "R1", "idle read", int'(flash_rd), 0);

        // R5 / R7: cold sequential run, only the first byte waits
        run(0, 16, s);
        chk(s == 4, "R5", "cold run stalls", s, 4);
        idle(6);
        // R6: loop back over cached words
        run(0, 16, s);
        chk(s == 0, "R6", "cached run stalls", s, 0);
        idle(6);
        // R8: jump while the prefetch of 0x48 is in flight
        run(32'h40, 5, s);
        chk(s == 4, "R7", "miss stalls", s, 4);
        fetch(32'h200, s);
        chk(s == 7, "R8", "jump over open read", s, 7);
        idle(6);
        fetch(32'h48, s);
        chk(s == 4, "R8", "discarded word not cached", s, 4);
        idle(6);
        // R6: 0x200 shares index 0 with 0x000
        fetch(32'h000, s);
        chk(s == 4, "R6", "evicted line misses", s, 4);
        idle(6);
        fetch(32'h00C, s);
        chk(s == 0, "R6", "other line still hits", s, 0);
        idle(6);
        // R4: same word again
        fetch(32'h00D, s);
        chk(s == 0, "R4", "buffer hit", s, 0);
        // R9: invalidate
        cycle(0, 0, 1);
        idle(6);
        fetch(32'h00C, s);
        chk(s == 4, "R9", "miss after invalidate", s, 4);

        // Mixed runs over 1 KiB: four words per cache index (R2, R3, R5, R6, R7, R8)
        rs = 32'h1357_2468;
        for (int k = 0; k < 400; k++) begin
            int a0, len, gap;
            rs  = rs * 32'd1103515245 + 32'd12345;
            a0  = int'((rs >> 8) & 32'h3FF);
            len = 1 + int'((rs >> 20) % 12);
            gap = int'((rs >> 27) % 6);
            run(a0, len, s);
            idle(gap);
            if (((rs >> 4) & 32'h1F) == 0) cycle(0, 0, 1);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule